// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and a 32-bit asynchronous static RAM array built from four byte-wide lanes. Each lane has its own active-low chip select and write enable. All lanes share one active-low output enable and a 19-bit word address. The host hands over one request at a time with a valid/ready handshake. Each request carries a byte address, write data, a read/write flag and a width code for 8, 16 or 32 bits. The controller then plays out the strobe sequence that the memory needs.

Every timing minimum of the memory is a nanosecond parameter. At elaboration each one is turned into a whole number of clock cycles, rounded up, with at least one cycle per phase. The same block therefore serves any clock rate and any speed grade. The block reports the end of each access with a one-cycle done pulse. Read data is registered in the last cycle of the read strobe. Byte lanes that the access did not select read back as zero.

The data bus is split into an output word, an input word and a drive enable. The drive enable is raised only while a write pulse and its hold phase are in progress. After every read the bus is left undriven for a release interval.

Top module: `asram_ctrl`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Address, data, width and direction are stored at that edge, and later changes on the request inputs do not affect the access in progress. `mem_addr` carries `req_addr[20:2]` and stays stable for the whole access.
- R2: Width code 2'b00 selects one lane, numbered by `req_addr[1:0]`. Code 2'b01 selects a lane pair: lanes 0 and 1 when `req_addr[1]` is 0, lanes 2 and 3 when it is 1. Codes 2'b10 and 2'b11 select all four lanes. Lane n uses data bits [8n+7:8n] and strobe bit n.
- R3: Lanes outside the selection keep `mem_cs_n` and `mem_we_n` high for the entire access. A lane's write enable is never low unless its chip select is low.
- R4: A read holds the selected chip selects and `mem_oe_n` low, with all write enables high, for the largest of the cycle time, address access, select access and output-enable access, each converted to cycles. With the default 5 ns clock this is 4 cycles.
- R5: `rsp_done` is high for exactly one cycle. It comes the cycle after the last strobe cycle: 4 cycles after acceptance for a default read and 5 for a default write. After a read, `rsp_rdata` holds the selected lanes' bytes with zero in unselected lanes, and it stays unchanged until the next read.
- R6: A write runs three phases. First comes setup, with the selected chip selects low and write enables high. Then the write pulse, with the write enables also low. Then hold, with chip selects still low and write enables high. `mem_oe_n` stays high throughout. The pulse lasts the larger of write pulse width and data-to-end-of-write, and is stretched if needed so that the whole write meets the write cycle time. The default is 1 setup cycle, 3 pulse cycles and 1 hold cycle.
- R7: `mem_dq_oe` is high exactly during the write pulse and hold cycles (4 cycles by default), never while `mem_oe_n` is low. During that time `mem_dq_o` carries the stored write data.
- R8: After a read, all strobes stay released and `req_ready` stays low for a release interval of ceil(output-release time / clock period) cycles, at least one (2 by default). Ready is therefore low for 6 cycles per default read and 5 per default write.
- R9: Whenever `req_ready` is high, all chip selects and write enables are high, `mem_oe_n` is high and `mem_dq_oe` is low.
- R10: While `rst_n` is low, `req_ready` is high, `rsp_done` is low, `rsp_rdata` is zero and all strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Width code: 00 byte, 01 half word, 10/11 word |
| req_addr | input | 21 | Byte address; bits [1:0] pick the lane or pair |
| req_wdata | input | 32 | Write data, already placed on its lanes |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 32 | Registered read data, zero in unselected lanes |
| mem_addr | output | 19 | Word address to the memory |
| mem_cs_n | output | 4 | Per-lane chip select, active low |
| mem_we_n | output | 4 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 32 | Data returned by the memory |

## Verification
The done pulse is due a fixed number of cycles after the accepting edge: 4 cycles for a read and 5 for a write at the default timing. The driver stamps each queued item with its acceptance cycle, and the monitor checks the exact difference when it pops that item on the done pulse. Strobe phases are measured as run lengths of consecutive low cycles, sampled on the falling clock edge: 4 for output enable, 3 for write enable and 4 for bus drive. Busy time is measured as the run length of ready being low: 6 cycles after a read and 5 after a write. Lane masks, the address and the driven data are compared against the front item on every sampled cycle of an access.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [1:0] {
      WID_8   = 2'b00,
      WID_16  = 2'b01,
      WID_32  = 2'b10,
      WID_32X = 2'b11
   } width_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_TURN  = 3'd2,
      ST_SETUP = 3'd3,
      ST_PULSE = 3'd4,
      ST_HOLD  = 3'd5
   } phase_e;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int cyc_of(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_lane_dec.sv
module asram_lane_dec
   import asram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LIDX_W = 2
) (
   input  width_e            width,
   input  logic [LIDX_W-1:0] lane_sel,
   output logic [LANES-1:0]  mask
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [LIDX_W-1:0] L_IDX = LIDX_W'(l);
      logic hit8, hit16;
      assign hit8  = (lane_sel == L_IDX);
      assign hit16 = (lane_sel[LIDX_W-1:1] == L_IDX[LIDX_W-1:1]);
      always_comb begin
         unique case (width)
            WID_8:   mask[l] = hit8;
            WID_16:  mask[l] = hit16;
            default: mask[l] = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap,
   input  logic [LANES-1:0]        mask,
   input  logic [LANES*LANE_W-1:0] dq_i,
   output logic [LANES*LANE_W-1:0] rdata
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata[l*LANE_W +: LANE_W] <= '0;
         else if (cap)
            rdata[l*LANE_W +: LANE_W] <= mask[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
      end
   end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int RD_CYC   = 4,
   parameter int TURN_CYC = 2,
   parameter int AS_CYC   = 1,
   parameter int WP_CYC   = 3,
   parameter int HD_CYC   = 1,
   parameter int CNT_W    = 3
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   is_write,
   output phase_e phase_o,
   output logic   rd_last_o,
   output logic   done_o
);

   phase_e           phase_q, phase_d;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             zero;

   asram_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .zero     (zero)
   );

   always_comb begin
      phase_d  = phase_q;
      load     = 1'b0;
      load_val = '0;
      unique case (phase_q)
         ST_IDLE: if (start) begin
            load = 1'b1;
            if (is_write) begin
               phase_d  = ST_SETUP;
               load_val = CNT_W'(AS_CYC - 1);
            end else begin
               phase_d  = ST_RD;
               load_val = CNT_W'(RD_CYC - 1);
            end
         end
         ST_RD: if (zero) begin
            phase_d  = ST_TURN;
            load     = 1'b1;
            load_val = CNT_W'(TURN_CYC - 1);
         end
         ST_TURN:  if (zero) phase_d = ST_IDLE;
         ST_SETUP: if (zero) begin
            phase_d  = ST_PULSE;
            load     = 1'b1;
            load_val = CNT_W'(WP_CYC - 1);
         end
         ST_PULSE: if (zero) begin
            phase_d  = ST_HOLD;
            load     = 1'b1;
            load_val = CNT_W'(HD_CYC - 1);
         end
         ST_HOLD:  if (zero) phase_d = ST_IDLE;
         default:  phase_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= ST_IDLE;
         done_o  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_o  <= zero && ((phase_q == ST_RD) || (phase_q == ST_HOLD));
      end
   end

   assign phase_o   = phase_q;
   assign rd_last_o = zero && (phase_q == ST_RD);

   // R5: the end-of-access pulse never lasts two cycles
   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: a write pulse is always entered from the setup phase
   p_pulse_after_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_q == ST_PULSE) |-> ($past(phase_q) == ST_SETUP));

   // R8: the release phase only follows a read
   p_turn_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase_q == ST_TURN) |-> ($past(phase_q) == ST_RD));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int LANES     = 4,
   parameter int LANE_W    = 8,
   parameter int CLK_NS    = 5,
   parameter int T_RC_NS   = 20,
   parameter int T_AA_NS   = 20,
   parameter int T_ACS_NS  = 20,
   parameter int T_OE_NS   = 10,
   parameter int T_WC_NS   = 20,
   parameter int T_WP_NS   = 15,
   parameter int T_AS_NS   = 0,
   parameter int T_DW_NS   = 10,
   parameter int T_DH_NS   = 0,
   parameter int T_WR_NS   = 0,
   parameter int T_HZ_NS   = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [1:0]               req_mode,
   input  logic [ADDR_W+1:0]        req_addr,
   input  logic [LANES*LANE_W-1:0]  req_wdata,
   output logic                     rsp_done,
   output logic [LANES*LANE_W-1:0]  rsp_rdata,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [LANES-1:0]         mem_cs_n,
   output logic [LANES-1:0]         mem_we_n,
   output logic                     mem_oe_n,
   output logic [LANES*LANE_W-1:0]  mem_dq_o,
   output logic                     mem_dq_oe,
   input  logic [LANES*LANE_W-1:0]  mem_dq_i
);

   localparam int DATA_W   = LANES * LANE_W;
   localparam int LIDX_W   = 2;
   localparam int RD_CYC   = imax(imax(cyc_of(T_RC_NS, CLK_NS), cyc_of(T_AA_NS, CLK_NS)),
                                  imax(cyc_of(T_ACS_NS, CLK_NS), cyc_of(T_OE_NS, CLK_NS)));
   localparam int AS_CYC   = cyc_of(T_AS_NS, CLK_NS);
   localparam int HD_CYC   = imax(cyc_of(T_DH_NS, CLK_NS), cyc_of(T_WR_NS, CLK_NS));
   localparam int WP_MIN   = imax(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_DW_NS, CLK_NS));
   localparam int WC_CYC   = cyc_of(T_WC_NS, CLK_NS);
   localparam int WP_CYC   = imax(WP_MIN, WC_CYC - AS_CYC - HD_CYC);
   localparam int TURN_CYC = cyc_of(T_HZ_NS, CLK_NS);
   localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), imax(imax(AS_CYC, HD_CYC), TURN_CYC));
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   if (LANES != 4) begin : g_chk_lanes
      $error("asram_ctrl: width modes need exactly four lanes");
   end
   if (CLK_NS < 1) begin : g_chk_clk
      $error("asram_ctrl: clock period must be at least 1 ns");
   end
   if (ADDR_W < 1) begin : g_chk_addr
      $error("asram_ctrl: address width must be positive");
   end

   phase_e              phase;
   logic                accept;
   logic                rd_last;
   logic [LANES-1:0]    mask_d, mask_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic                active;

   assign req_ready = (phase == ST_IDLE);
   assign accept    = req_valid && req_ready;

   asram_lane_dec #(.LANES(LANES), .LIDX_W(LIDX_W)) dec_i (
      .width    (width_e'(req_mode)),
      .lane_sel (req_addr[LIDX_W-1:0]),
      .mask     (mask_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         mask_q  <= mask_d;
         addr_q  <= req_addr[ADDR_W+1:LIDX_W];
         wdata_q <= req_wdata;
      end
   end

   asram_seq #(
      .RD_CYC   (RD_CYC),
      .TURN_CYC (TURN_CYC),
      .AS_CYC   (AS_CYC),
      .WP_CYC   (WP_CYC),
      .HD_CYC   (HD_CYC),
      .CNT_W    (CNT_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .is_write  (req_write),
      .phase_o   (phase),
      .rd_last_o (rd_last),
      .done_o    (rsp_done)
   );

   asram_rdcap #(.LANES(LANES), .LANE_W(LANE_W)) cap_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (rd_last),
      .mask  (mask_q),
      .dq_i  (mem_dq_i),
      .rdata (rsp_rdata)
   );

   assign active    = (phase == ST_RD) || (phase == ST_SETUP) ||
                      (phase == ST_PULSE) || (phase == ST_HOLD);
   assign mem_addr  = addr_q;
   assign mem_cs_n  = active ? ~mask_q : '1;
   assign mem_we_n  = (phase == ST_PULSE) ? ~mask_q : '1;
   assign mem_oe_n  = (phase != ST_RD);
   assign mem_dq_o  = wdata_q;
   assign mem_dq_oe = (phase == ST_PULSE) || (phase == ST_HOLD);

   // R7: the controller never drives while the memory may drive
   p_no_bus_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R3: a lane write strobe only inside its own chip select
   p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mem_we_n) & mem_cs_n) == '0);

   // R2: never three lanes at once
   p_lane_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~mem_cs_n) != 3);

   // R9: idle means fully released
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&mem_cs_n && &mem_we_n && mem_oe_n && !mem_dq_oe));

   // R1: address and write data stay put while busy
   p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

   // R4: write strobes stay high while reading
   p_read_no_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> &mem_we_n);

endmodule

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

   localparam int RD_C   = 4;
   localparam int WR_C   = 5;
   localparam int WP_C   = 3;
   localparam int DRV_C  = 4;
   localparam int RBUSY  = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_mode = 2'b00;
   logic [20:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic [18:0] mem_addr;
   logic [3:0]  mem_cs_n;
   logic [3:0]  mem_we_n;
   logic        mem_oe_n;
   logic [31:0] mem_dq_o;
   logic        mem_dq_oe;
   logic [31:0] mem_dq_i;

   always #2.5 clk = ~clk;

   asram_ctrl dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_mode (req_mode), .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_done (rsp_done), .rsp_rdata (rsp_rdata),
      .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
      .mem_oe_n (mem_oe_n), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
      .mem_dq_i (mem_dq_i)
   );

   typedef struct {
      bit          wr;
      logic [20:0] baddr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic [3:0]  mask;
      int          acc;
   } item_t;

   item_t       sb_q[$];
   logic [31:0] shadow [256];
   logic [31:0] model  [256];
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   bit          finished = 0;
   bit          mon_en = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic logic [3:0] exp_mask(input logic [1:0] mode, input logic [1:0] ls);
      case (mode)
         2'b00:   return 4'b0001 << ls;
         2'b01:   return ls[1] ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] byte_mask(input logic [3:0] m);
      logic [31:0] r;
      for (int l = 0; l < 4; l++) r[l*8 +: 8] = {8{m[l]}};
      return r;
   endfunction

   // memory model: unselected lanes return junk so zeroing is visible
   always_comb begin
      for (int l = 0; l < 4; l++)
         mem_dq_i[l*8 +: 8] = (!mem_oe_n && !mem_cs_n[l] && mem_we_n[l])
                              ? model[mem_addr[7:0]][l*8 +: 8] : 8'hA5;
   end

   always @(posedge clk) cyc <= cyc + 1;

   int  oe_run = 0, we_run = 0, dq_run = 0, rdy_run = 0;
   bit  done_prev = 0;
   bit  last_wr = 0;

   always @(negedge clk) begin
      if (rst_n && mon_en && !finished) begin
         for (int l = 0; l < 4; l++)
            if (!mem_cs_n[l] && !mem_we_n[l]) begin
               check(mem_dq_oe, "R7 drive during pulse", {31'b0, mem_dq_oe}, 32'd1);
               model[mem_addr[7:0]][l*8 +: 8] = mem_dq_o[l*8 +: 8];
            end
         if (mem_cs_n != 4'hF) begin
            if (sb_q.size() == 0)
               check(1'b0, "R3 strobe with no access", {28'b0, mem_cs_n}, 32'hF);
            else begin
               check(~mem_cs_n == sb_q[0].mask, "R2 lane mask", {28'b0, ~mem_cs_n},
                     {28'b0, sb_q[0].mask});
               check((~mem_we_n & ~sb_q[0].mask) == 4'b0, "R3 unselected we_n",
                     {28'b0, mem_we_n}, {28'b0, ~sb_q[0].mask});
               check(mem_addr == sb_q[0].baddr[20:2], "R1 address", {13'b0, mem_addr},
                     {13'b0, sb_q[0].baddr[20:2]});
               if (mem_oe_n && !mem_dq_oe)
                  check(sb_q[0].wr, "R6 setup only on writes", 32'd0, 32'd1);
               if (mem_dq_oe)
                  check(mem_dq_o == sb_q[0].wdata, "R7 driven data", mem_dq_o,
                        sb_q[0].wdata);
            end
         end
         if (!mem_oe_n) begin
            oe_run++;
            check(&mem_we_n, "R4 we_n high in read", {28'b0, mem_we_n}, 32'hF);
         end else if (oe_run != 0) begin
            check(oe_run == RD_C, "R4 read strobe length", oe_run, RD_C);
            oe_run = 0;
         end
         if (mem_we_n != 4'hF) we_run++;
         else if (we_run != 0) begin
            check(we_run == WP_C, "R6 write pulse length", we_run, WP_C);
            we_run = 0;
         end
         if (mem_dq_oe) begin
            dq_run++;
            check(mem_oe_n, "R7 no drive with oe_n low", {31'b0, mem_oe_n}, 32'd1);
         end else if (dq_run != 0) begin
            check(dq_run == DRV_C, "R7 drive length", dq_run, DRV_C);
            dq_run = 0;
         end
         if (rsp_done) begin
            check(!done_prev, "R5 done single cycle", 32'd1, 32'd0);
            if (sb_q.size() == 0)
               check(1'b0, "R5 unexpected done", 32'd1, 32'd0);
            else begin
               item_t it;
               it = sb_q.pop_front();
               check((cyc - it.acc) == (it.wr ? WR_C : RD_C), "R5 done latency",
                     cyc - it.acc, it.wr ? WR_C : RD_C);
               if (!it.wr)
                  check(rsp_rdata == it.exp, "R5 read data", rsp_rdata, it.exp);
               last_wr = it.wr;
            end
         end
         done_prev = rsp_done;
         if (!req_ready) rdy_run++;
         else begin
            if (rdy_run != 0) begin
               check(rdy_run == (last_wr ? WR_C : RBUSY), "R8 busy length", rdy_run,
                     last_wr ? WR_C : RBUSY);
               rdy_run = 0;
            end
            check(&mem_cs_n && &mem_we_n && mem_oe_n && !mem_dq_oe, "R9 idle released",
                  {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h3FE);
         end
      end
   end

   task automatic access(input bit wr, input logic [1:0] mode, input logic [20:0] baddr,
                         input logic [31:0] wdata);
      item_t       it;
      logic [31:0] bm;
      it.wr    = wr;
      it.baddr = baddr;
      it.wdata = wdata;
      it.mask  = exp_mask(mode, baddr[1:0]);
      bm       = byte_mask(it.mask);
      if (wr) begin
         shadow[baddr[9:2]] = (shadow[baddr[9:2]] & ~bm) | (wdata & bm);
         it.exp = '0;
      end else
         it.exp = shadow[baddr[9:2]] & bm;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_mode  = mode;
      req_addr  = baddr;
      req_wdata = wdata;
      while (!req_ready) @(negedge clk);
      it.acc = cyc + 1;
      sb_q.push_back(it);
      @(negedge clk);
      // R1: disturb the request inputs once the access has been taken
      req_valid = 1'b0;
      req_write = ~wr;
      req_mode  = ~mode;
      req_addr  = ~baddr;
      req_wdata = ~wdata;
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         shadow[i] = '0;
         model[i]  = '0;
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      check(req_ready, "R10 ready in reset", {31'b0, req_ready}, 32'd1);
      check(!rsp_done && rsp_rdata == '0, "R10 done/rdata in reset", rsp_rdata, 32'd0);
      check(&mem_cs_n && &mem_we_n && mem_oe_n && !mem_dq_oe, "R10 strobes in reset",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h3FE);
      rst_n = 1'b1;
      mon_en = 1'b1;
      @(negedge clk);
      access(1'b1, 2'b10, {19'd3, 2'b00}, 32'h1122_3344);      // R6 word write
      access(1'b0, 2'b10, {19'd3, 2'b00}, 32'h0);              // R4 word read
      access(1'b1, 2'b00, {19'd3, 2'b10}, 32'hDEAD_BEEF);      // R2 byte lane 2
      access(1'b0, 2'b00, {19'd3, 2'b10}, 32'h0);              // R5 zeroed lanes
      access(1'b0, 2'b00, {19'd3, 2'b01}, 32'h0);              // R2 byte lane 1
      access(1'b1, 2'b01, {19'd5, 2'b10}, 32'hCAFE_F00D);      // R2 upper pair
      access(1'b0, 2'b10, {19'd5, 2'b00}, 32'h0);
      access(1'b0, 2'b01, {19'd3, 2'b01}, 32'h0);              // R2 lower pair, bit0 ignored
      access(1'b1, 2'b11, {19'h7FF40, 2'b00}, 32'h0BAD_F00D);  // R2 code 11 as word
      access(1'b0, 2'b11, {19'h7FF40, 2'b00}, 32'h0);
      access(1'b1, 2'b00, {19'h7FF40, 2'b11}, 32'h5500_0000);  // R3 lane 3 only
      access(1'b1, 2'b10, {19'd9, 2'b00}, 32'h0102_0304);      // R8 write after write
      access(1'b0, 2'b10, {19'h7FF40, 2'b00}, 32'h0);
      access(1'b0, 2'b10, {19'd9, 2'b00}, 32'h0);              // R8 read after read
      repeat (10) @(negedge clk);
      check(sb_q.size() == 0, "R5 all accesses completed", sb_q.size(), 32'd0);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule